// File: doc/BRIEF.md
# SPI Master with Register Port and Byte FIFOs

This block is a serial peripheral interface master. A host reaches it through a small word-addressed register port. Through that port the host sets the mode, the chip-select choice and the line polarities, sets the bit-rate divider, and moves bytes through a data window. Bytes written to the data window queue in a transmit FIFO. While the transfer-enable bit is set, the shift engine takes each queued byte and clocks it out most significant bit first on `sclk`/`mosi`. At the same time it clocks the returning byte in from `miso` and pushes it into a receive FIFO, which the host drains by reading the data window.

The chip-select line picked by the select field stays asserted for as long as transfer-enable is set, including the gaps between bytes. Each of the three lines has its own active level. The completion flag means "enabled, nothing queued, engine idle". It therefore reads as set straight after enable, and an interrupt-driven host fills the FIFO from its first interrupt. A second interrupt source flags a receive FIFO that is three-quarters full.

Top module: `spim_top`

## Requirements
- R1: After reset the control word reads 0x0004_0000 (only the transmit-space flag set), every chip-select line is high, `sclk` is 0 and `irq` is 0.
- R2: Word offsets are control at 0x0, data window at 0x4 and divider at 0x8 (address bits [1:0] are ignored). Offset 0xC reads 0 and ignores writes. The divider reads back its 16 written bits. In the control word the fields read back as written: select at [1:0], sample-phase at 2, idle level at 3, transfer-enable at 7, done-interrupt enable at 9, fill-interrupt enable at 10, and per-line active levels at 21 (line 0), 22 (line 1) and 23 (line 2).
- R3: Status bits of the control word are done at 16, receive-not-empty at 17, transmit-not-full at 18, receive-nearly-full at 19 and receive-full at 20. Done equals transfer-enable AND transmit FIFO empty AND engine idle, so it reads 1 in the first cycle after enable when nothing is queued.
- R4: One `sclk` period lasts D core cycles, where D is the divider value with bit 0 forced to 0. D = 0 gives 65536.
- R5: Each byte is 8 bits, sent most significant bit first, with `sclk` resting at the idle-level bit. With sample-phase 0, `mosi` changes on trailing edges and the first edge samples. With sample-phase 1, `mosi` changes on leading edges after the first and trailing edges sample. With `miso` tied to `mosi`, the received byte equals the sent byte in all four modes.
- R6: While transfer-enable is set, the line named by select 0..2 is driven to its active level and the other lines to their inactive levels. The line stays asserted between queued bytes. Select value 3 asserts no line.
- R7: Clearing transfer-enable stops the shift engine within one cycle without pushing a partial byte, returns `sclk` to the idle level and drives all lines inactive.
- R8: Writing the control word with bit 4 set empties the transmit FIFO, and with bit 5 set empties the receive FIFO. Neither bit is stored.
- R9: Each FIFO holds 16 bytes. A data write into a full transmit FIFO is dropped. A data read from an empty receive FIFO returns 0 and changes nothing.
- R10: Receive-nearly-full is set exactly when the receive FIFO holds 12 or more bytes.
- R11: `irq` is high exactly when (done AND done-interrupt enable) OR (receive-nearly-full AND fill-interrupt enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive FIFO at the data window) |
| addr | input | 4 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 3 | Chip-select lines, bit i is line i |
| irq | output | 1 | Interrupt request |

## Verification
Two behaviours are hard to reach from the ports. The first is a transfer-enable drop in the middle of a byte. The bench uses a slow divider, waits until `sclk` has left its idle level, then clears the enable. It then checks that `sclk` and the lines fall back and that no byte reaches the receive FIFO. The second is the slowest divider setting. It is measured directly as one full 65536-cycle period. Sample phase cannot be seen through the loopback alone, so the bench reads `mosi` at the first and second `sclk` edges and checks that it moves only in the mode that shifts on trailing edges.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int NUM_CS = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              run;
    logic              load;
    logic              cpol;
    logic              cpha;
    logic [BYTE_W-1:0] txByte;
  } engCmd_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  engCmd_t           cmd,
  input  logic [HALF_W-1:0] halfPer,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte
);
  logic [HALF_W-1:0] halfCnt;
  logic [3:0]        edgeCnt;
  logic              lvl;
  logic [BYTE_W-1:0] txSh, rxSh;
  logic              sampleNow, lastEdge, edgeNow;

  assign sclk      = cmd.cpol ^ lvl;
  assign mosi      = txSh[BYTE_W-1];
  assign edgeNow   = busy && (halfCnt == HALF_W'(1));
  assign sampleNow = (edgeCnt[0] == cmd.cpha);
  assign lastEdge  = (edgeCnt == 4'd15);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      lvl     <= 1'b0;
      edgeCnt <= '0;
      halfCnt <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      rxValid <= 1'b0;
      if (!cmd.run) begin
        busy <= 1'b0;
        lvl  <= 1'b0;
      end else if (cmd.load) begin
        busy    <= 1'b1;
        lvl     <= 1'b0;
        edgeCnt <= '0;
        halfCnt <= halfPer;
        txSh    <= cmd.txByte;
      end else if (edgeNow) begin
        halfCnt <= halfPer;
        lvl     <= ~lvl;
        edgeCnt <= edgeCnt + 4'd1;
        if (sampleNow) rxSh <= {rxSh[BYTE_W-2:0], miso};
        else if (edgeCnt != 4'd0 && !lastEdge) txSh <= {txSh[BYTE_W-2:0], 1'b0};
        if (lastEdge) begin
          busy    <= 1'b0;
          rxValid <= 1'b1;
          rxByte  <= sampleNow ? {rxSh[BYTE_W-2:0], miso} : rxSh;
        end
      end else if (busy) begin
        halfCnt <= halfCnt - HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int HALF_W = DIV_W - 1,
  localparam int RXR_LVL = (DEPTH * 3) / 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              engBusy,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output engCmd_t           cmd,
  output logic [HALF_W-1:0] halfPer,
  output logic [NUM_CS-1:0] linePol,
  output logic [NUM_CS-1:0] csOut,
  output logic              irq
);
  logic [1:0]       csSel;
  logic             cpha, cpol, ta, intDone, intFill;
  logic [DIV_W-1:0] divReg;
  logic isCtrl, isData, isDiv;
  logic clrTx, clrRx;
  logic [BYTE_W-1:0] txHead, rxHead;
  logic [CNT_W-1:0]  txCnt, rxCnt;
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic done, rxr;
  logic [31:0] ctrlWord;

  assign isCtrl = (addr[3:2] == 2'd0);
  assign isData = (addr[3:2] == 2'd1);
  assign isDiv  = (addr[3:2] == 2'd2);
  assign clrTx  = wrEn && isCtrl && wrData[4];
  assign clrRx  = wrEn && isCtrl && wrData[5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSel <= '0; cpha <= 1'b0; cpol <= 1'b0; ta <= 1'b0;
      intDone <= 1'b0; intFill <= 1'b0; linePol <= '0; divReg <= '0;
    end else if (wrEn) begin
      if (isCtrl) begin
        csSel   <= wrData[1:0];
        cpha    <= wrData[2];
        cpol    <= wrData[3];
        ta      <= wrData[7];
        intDone <= wrData[9];
        intFill <= wrData[10];
        linePol <= wrData[23:21];
      end
      if (isDiv) divReg <= wrData[DIV_W-1:0];
    end
  end

  spim_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .clear(clrTx), .push(wrEn && isData),
    .pop(cmd.load), .din(wrData[BYTE_W-1:0]), .dout(txHead),
    .count(txCnt), .empty(txEmpty), .full(txFull));

  spim_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .clear(clrRx), .push(rxValid),
    .pop(rdEn && isData), .din(rxByte), .dout(rxHead),
    .count(rxCnt), .empty(rxEmpty), .full(rxFull));

  assign cmd.run    = ta;
  assign cmd.load   = ta && !txEmpty && !engBusy;
  assign cmd.cpol   = cpol;
  assign cmd.cpha   = cpha;
  assign cmd.txByte = txHead;
  assign halfPer    = divReg[DIV_W-1:1];

  assign done = ta && txEmpty && !engBusy;
  assign rxr  = (rxCnt >= CNT_W'(RXR_LVL));
  assign irq  = (done && intDone) || (rxr && intFill);

  genvar i;
  generate
    for (i = 0; i < NUM_CS; i++) begin : gCs
      assign csOut[i] = (ta && csSel == 2'(i)) ? linePol[i] : ~linePol[i];
    end
  endgenerate

  assign ctrlWord = {8'd0, linePol, rxFull, rxr, !txFull, !rxEmpty, done,
                     5'd0, intFill, intDone, 1'b0, ta, 3'd0, cpol, cpha, csSel};

  always_comb begin
    case (addr[3:2])
      2'd0:    rdData = ctrlWord;
      2'd1:    rdData = rxEmpty ? 32'd0 : {{(32-BYTE_W){1'b0}}, rxHead};
      2'd2:    rdData = {{(32-DIV_W){1'b0}}, divReg};
      default: rdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  csOut,
  output logic        irq
);
  localparam int HALF_W = DIV_W - 1;

  engCmd_t           cmd;
  logic [HALF_W-1:0] halfPer;
  logic              engBusy, rxValid;
  logic [BYTE_W-1:0] rxByte;
  logic [NUM_CS-1:0] linePol;

  spim_ctrl #(.DEPTH(DEPTH), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .engBusy(engBusy), .rxValid(rxValid),
    .rxByte(rxByte), .cmd(cmd), .halfPer(halfPer), .linePol(linePol),
    .csOut(csOut), .irq(irq));

  spim_engine #(.HALF_W(HALF_W)) uEngine (
    .clk(clk), .rstN(rstN), .cmd(cmd), .halfPer(halfPer), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(engBusy), .rxValid(rxValid),
    .rxByte(rxByte));
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input engCmd_t           cmd,
  input logic              engBusy,
  input logic              sclk,
  input logic [NUM_CS-1:0] csOut,
  input logic [NUM_CS-1:0] linePol
);
  logic [NUM_CS-1:0] csActive;
  assign csActive = ~(csOut ^ linePol);

  assert_single_cs_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(csActive) <= 1);

  assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |-> (csActive == '0));

  assert_engine_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> !engBusy);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    !engBusy |-> (sclk == cmd.cpol));

  assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> engBusy);
endmodule

bind spim_top spim_checker uChk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .engBusy(engBusy), .sclk(sclk),
  .csOut(csOut), .linePol(linePol));

// File: tb/tb_spim_top.sv
module tb_spim_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {cpol, cpha, divider[15:0], byte[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {2'b00, 16'd2,  8'hA5},
    {2'b01, 16'd4,  8'h3C},
    {2'b10, 16'd6,  8'h81},
    {2'b11, 16'd8,  8'h7E},
    {2'b00, 16'd7,  8'hC3},
    {2'b11, 16'd2,  8'h5A},
    {2'b01, 16'd3,  8'h0F}
  };

  logic clk = 1'b0;
  logic rstN, wrEn, rdEn, miso, sclk, mosi, irq;
  logic [3:0] addr;
  logic [31:0] wrData, rdData;
  logic [2:0] csOut;
  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = mosi;

  spim_top dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csOut(csOut), .irq(irq));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitDone(output bit csHeld, input int line);
    logic [31:0] s;
    csHeld = 1'b1;
    do begin
      rd(4'h0, s);
      if (csOut[line] !== 1'b0) csHeld = 1'b0;
    end while (!s[16]);
  endtask

  task automatic measure(output int per, output logic m0, output logic m1);
    int t [3];
    logic prev;
    int n;
    prev = sclk; n = 0; m0 = 1'b0; m1 = 1'b0;
    while (n < 3) begin
      @(negedge clk);
      if (sclk !== prev) begin
        prev = sclk;
        t[n] = cyc;
        if (n == 0) m0 = mosi;
        if (n == 1) m1 = mosi;
        n++;
      end
    end
    per = t[2] - t[0];
  endtask

  task automatic finish();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish();
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    logic [15:0] dv;
    logic cp, ch, m0, m1;
    int per, expPer;
    bit held;

    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, d);
    check(d == 32'h0004_0000, "R1 reset control word", d, 32'h0004_0000);
    check(csOut == 3'b111 && sclk == 1'b0 && irq == 1'b0, "R1 reset pins",
          {csOut, sclk, irq}, 5'b11100);

    // R2 register map and readback
    wr(4'h0, 32'h00A0_060E);
    rd(4'h0, d);
    check(d == 32'h00A4_060E, "R2 control readback", d, 32'h00A4_060E);
    check(csOut == 3'b010, "R6 inactive levels follow per-line polarity", csOut, 3'b010);
    check(irq == 1'b0, "R11 no irq while disabled", irq, 0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d);
    check(d == 32'd0, "R2 unused offset reads zero", d, 0);
    wr(4'h8, 32'hABCD_1234);
    rd(4'h8, d);
    check(d == 32'h0000_1234, "R2 divider readback", d, 32'h1234);

    // R3 done immediately after enable, R11 done interrupt
    wr(4'h0, 32'h0000_0280);
    rd(4'h0, d);
    check(d == 32'h0005_0280, "R3 done right after enable", d, 32'h0005_0280);
    check(irq == 1'b1, "R11 done interrupt", irq, 1);
    check(csOut == 3'b110, "R6 line 0 active low", csOut, 3'b110);
    wr(4'h0, 32'h0000_0083);
    check(csOut == 3'b111, "R6 select 3 asserts nothing", csOut, 3'b111);
    wr(4'h0, 32'h0040_0081);
    check(csOut == 3'b111, "R6 line 1 active high", csOut, 3'b111);
    wr(4'h0, 32'h0040_0001);
    check(csOut == 3'b101, "R6 line 1 released", csOut, 3'b101);
    wr(4'h0, 32'h0000_0000);

    // R4, R5 mode and divider table with loopback
    for (int i = 0; i < NVEC; i++) begin
      cp = VEC[i][25]; ch = VEC[i][24]; dv = VEC[i][23:8]; b = VEC[i][7:0];
      expPer = ((dv & 16'hFFFE) == 16'd0) ? 65536 : int'(dv & 16'hFFFE);
      wr(4'h8, {16'd0, dv});
      wr(4'h0, {24'd0, 1'b1, 3'b000, cp, ch, 2'b00});
      check(sclk == cp, "R5 idle level before byte", sclk, cp);
      wr(4'h4, {24'd0, b});
      measure(per, m0, m1);
      check(per == expPer, "R4 sclk period", per, expPer);
      check(m0 == b[7], "R5 msb first", m0, b[7]);
      check(m1 == (ch ? b[7] : b[6]), "R5 phase of mosi change", m1, ch ? b[7] : b[6]);
      waitDone(held, 0);
      check(sclk == cp, "R5 idle level after byte", sclk, cp);
      rd(4'h4, d);
      check(d == {24'd0, b}, "R5 loopback byte", d, b);
      wr(4'h0, 32'h0000_0000);
    end

    // R9 overflow, R10 threshold, R11 fill interrupt
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h0000_0030);
    for (int i = 0; i < 17; i++) wr(4'h4, (i * 7 + 3) & 32'hFF);
    rd(4'h0, d);
    check(d[18] == 1'b0, "R9 transmit full", d[18], 0);
    wr(4'h0, 32'h0000_0480);
    waitDone(held, 0);
    check(held, "R6 line held between bytes", held, 1);
    rd(4'h0, d);
    check(d == 32'h001F_0480, "R3 R10 status with 16 received", d, 32'h001F_0480);
    check(irq == 1'b1, "R11 fill interrupt", irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(4'h4, d);
      check(d == ((i * 7 + 3) & 32'hFF), "R9 receive order", d, (i * 7 + 3) & 32'hFF);
    end
    rd(4'h4, d);
    check(d == 32'd0, "R9 empty read returns zero", d, 0);
    rd(4'h0, d);
    check(d == 32'h0005_0480, "R9 dropped 17th byte", d, 32'h0005_0480);
    check(irq == 1'b0, "R11 no irq below threshold", irq, 0);
    for (int i = 0; i < 11; i++) wr(4'h4, 32'h55);
    waitDone(held, 0);
    rd(4'h0, d);
    check(d[19] == 1'b0 && irq == 1'b0, "R10 eleven bytes below threshold", {d[19], irq}, 0);
    wr(4'h4, 32'h66);
    waitDone(held, 0);
    rd(4'h0, d);
    check(d[19] == 1'b1 && irq == 1'b1, "R10 twelve bytes reach threshold", {d[19], irq}, 3);
    wr(4'h0, 32'h0000_04A0);
    rd(4'h0, d);
    check(d[17] == 1'b0, "R8 receive clear", d[17], 0);

    // R8 transmit clear
    wr(4'h0, 32'h0000_0000);
    for (int i = 0; i < 3; i++) wr(4'h4, 32'h11);
    wr(4'h0, 32'h0000_0010);
    wr(4'h0, 32'h0000_0080);
    rd(4'h0, d);
    check(d == 32'h0005_0080, "R8 transmit clear leaves done", d, 32'h0005_0080);
    repeat (40) @(negedge clk);
    rd(4'h0, d);
    check(d[17] == 1'b0, "R8 nothing shifted after clear", d[17], 0);

    // R7 abort mid-byte
    wr(4'h8, 32'd40);
    wr(4'h0, 32'h0000_0088);
    wr(4'h4, 32'h99);
    repeat (30) @(negedge clk);
    check(sclk == 1'b0, "R7 byte in flight", sclk, 0);
    wr(4'h0, 32'h0000_0008);
    check(csOut == 3'b111, "R7 lines released", csOut, 3'b111);
    @(negedge clk);
    check(sclk == 1'b1, "R7 sclk back to idle", sclk, 1);
    repeat (60) @(negedge clk);
    rd(4'h0, d);
    check(d[17] == 1'b0 && sclk == 1'b1, "R7 no partial byte", {d[17], sclk}, 1);

    // R4 slowest setting
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h0000_0080);
    wr(4'h4, 32'h3C);
    measure(per, m0, m1);
    check(per == 65536, "R4 zero divider period", per, 65536);
    wr(4'h0, 32'h0000_0000);

    finish();
  end
endmodule